// File: doc/BRIEF.md
# Prescaled Dual Timer with Toggle and PWM Outputs

This block provides two 8-bit counting channels, a low channel and a high channel, both advanced by a shared programmable prescaler. A two-bit mode selects how they are used. The channels can run as two free-standing interval timers that flip their outputs, or as two PWM generators. They can also be chained into one 16-bit timer whose high channel counts the low channel's period ends and flips the high output. In the chained modes the low channel keeps driving its own output, either as an interval toggle or as a PWM waveform.

Software writes four registers through a single-cycle write port. Prescale, low and high values are staged and only take effect at the next period boundary of the unit that uses them. This keeps a running waveform free of glitches. A write to the mode register restarts the whole block at once. Each channel raises a one-cycle interrupt pulse at the end of each of its periods. All outputs are registered.

Top module: `dual_tmr`

## Requirements
- R1: While `rst` is high, and on the cycle after, `out_lo`, `out_hi`, `irq_lo` and `irq_hi` are 0. The mode, the staged values and the active values are all 0.
- R2: With prescale value P (write address 1), the counters advance once every P+1 clocks.
- R3: In mode 0 (write address 0, value 0), the low channel counts 0..L, where L is written at address 2. At the step where the count equals L it wraps to 0, `out_lo` inverts and `irq_lo` pulses. One low period is therefore (P+1)(L+1) clocks.
- R4: In mode 0, the high channel behaves the same way as the low channel but independently, using H written at address 3 and driving `out_hi`.
- R5: In mode 1, both channels count 0..255 and wrap. Each output is high while its count is below its compare value and low otherwise, one clock after the count. A compare value of 0 keeps the output low.
- R6: In mode 2, the low channel is an interval toggle timer as in R3. The high channel advances only on low period ends. It inverts `out_hi` and pulses `irq_hi` after H+1 of them.
- R7: In mode 3, the low channel is a PWM as in R5, and its period ends at each 255 wrap. The high channel counts these wraps as in R6.
- R8: A write to address 1, 2 or 3 does not change the running period or compare value. It is taken at the next period end of that unit: the prescaler's wrap, or the channel's period end.
- R9: A write to address 0 loads the mode from bits 1:0 and restarts the block on that edge. Counters go to 0, outputs and flags go to 0, and all staged values become active.
- R10: `irq_lo` and `irq_hi` are one-clock pulses, one per period end of their channel. In toggle operation each pulse coincides with an inversion of the matching output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 mode, 1 prescale, 2 low value, 3 high value |
| wr_data | input | CNT_W | Write data |
| out_lo | output | 1 | Low channel output |
| out_hi | output | 1 | High channel output |
| irq_lo | output | 1 | Low channel period-end pulse |
| irq_hi | output | 1 | High channel period-end pulse |

## Verification
The properties assume that the mode register changes only through a restart write, so a mode read one edge later still describes the update that edge made. The stimulus honours this, because every mode change goes through address 0. The properties also assume that no write lands inside reset. The bench drives writes only after reset has been released, one write per cycle, on the falling edge. It runs every mode, changes staged values mid-period, and restarts and resets the block while it is running.

// File: rtl/dual_tmr_pkg.sv
package dual_tmr_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_MODE = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_PRE  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_LO   = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_HI   = 2'd3;

  typedef enum logic [1:0] {
    MODE_TOG2   = 2'd0,
    MODE_PWM2   = 2'd1,
    MODE_CASC_T = 2'd2,
    MODE_CASC_P = 2'd3
  } tmr_mode_e;

  function automatic logic lo_is_pwm(tmr_mode_e m);
    return (m == MODE_PWM2) || (m == MODE_CASC_P);
  endfunction

  function automatic logic hi_is_pwm(tmr_mode_e m);
    return (m == MODE_PWM2);
  endfunction

  function automatic logic hi_chained(tmr_mode_e m);
    return (m == MODE_CASC_T) || (m == MODE_CASC_P);
  endfunction
endpackage

// File: rtl/dual_tmr_prescaler.sv
module dual_tmr_prescaler #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic [PRE_W-1:0] stage_val,
  output logic             tick
);
  logic [PRE_W-1:0] cnt;
  logic [PRE_W-1:0] limit;

  assign tick = (cnt == limit);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      limit <= '0;
    end else if (restart) begin
      cnt   <= '0;
      limit <= stage_val;
    end else if (tick) begin
      cnt   <= '0;
      limit <= stage_val;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/dual_tmr_channel.sv
module dual_tmr_channel #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             step,
  input  logic             pwm,
  input  logic [CNT_W-1:0] stage_val,
  output logic             period_end,
  output logic             pin,
  output logic             pulse
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] active;
  logic             at_wrap;

  // PWM runs the full count range; toggle timing wraps at the active period.
  assign at_wrap    = pwm ? (cnt == CNT_MAX) : (cnt == active);
  assign period_end = step && at_wrap;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      active <= '0;
      pin    <= 1'b0;
      pulse  <= 1'b0;
    end else if (restart) begin
      cnt    <= '0;
      active <= stage_val;
      pin    <= 1'b0;
      pulse  <= 1'b0;
    end else begin
      pulse <= period_end;
      if (pwm) pin <= (cnt < active);
      else     pin <= pin ^ period_end;
      if (step) cnt <= period_end ? '0 : cnt + 1'b1;
      if (period_end) active <= stage_val;
    end
  end
endmodule

// File: rtl/dual_tmr.sv
module dual_tmr
  import dual_tmr_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic             out_lo,
  output logic             out_hi,
  output logic             irq_lo,
  output logic             irq_hi
);
  tmr_mode_e        mode_q;
  logic [PRE_W-1:0] pre_stage;
  logic [CNT_W-1:0] lo_stage;
  logic [CNT_W-1:0] hi_stage;
  logic             restart;
  logic             tick;
  logic             lo_end;
  logic             hi_end;
  logic             hi_step;

  assign restart = wr_en && (wr_addr == ADDR_MODE);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= MODE_TOG2;
      pre_stage <= '0;
      lo_stage  <= '0;
      hi_stage  <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        ADDR_MODE: mode_q    <= tmr_mode_e'(wr_data[1:0]);
        ADDR_PRE:  pre_stage <= wr_data[PRE_W-1:0];
        ADDR_LO:   lo_stage  <= wr_data;
        default:   hi_stage  <= wr_data;
      endcase
    end
  end

  dual_tmr_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst(rst), .restart(restart),
    .stage_val(pre_stage), .tick(tick)
  );

  dual_tmr_channel #(.CNT_W(CNT_W)) u_lo (
    .clk(clk), .rst(rst), .restart(restart), .step(tick),
    .pwm(lo_is_pwm(mode_q)), .stage_val(lo_stage),
    .period_end(lo_end), .pin(out_lo), .pulse(irq_lo)
  );

  // In the chained modes the high channel counts low period ends.
  assign hi_step = hi_chained(mode_q) ? lo_end : tick;

  dual_tmr_channel #(.CNT_W(CNT_W)) u_hi (
    .clk(clk), .rst(rst), .restart(restart), .step(hi_step),
    .pwm(hi_is_pwm(mode_q)), .stage_val(hi_stage),
    .period_end(hi_end), .pin(out_hi), .pulse(irq_hi)
  );
endmodule

// File: rtl/dual_tmr_chk.sv
module dual_tmr_chk (
  input logic       clk,
  input logic       rst,
  input logic       restart,
  input logic [1:0] mode,
  input logic       out_lo,
  input logic       out_hi,
  input logic       irq_lo,
  input logic       irq_hi
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    $past(rst) |-> (!out_lo && !out_hi && !irq_lo && !irq_hi));

  assert_restart_clear_R9: assert property (@(posedge clk) disable iff (rst)
    $past(restart) |-> (!out_lo && !out_hi && !irq_lo && !irq_hi));

  assert_lo_toggle_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(restart) && !$past(rst) && !mode[0])
      |-> ((out_lo != $past(out_lo)) == irq_lo));

  assert_hi_toggle_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    (!$past(restart) && !$past(rst) && (mode != 2'd1))
      |-> ((out_hi != $past(out_hi)) == irq_hi));

  assert_chain_follows_low_R6: assert property (@(posedge clk) disable iff (rst)
    (mode[1] && irq_hi) |-> irq_lo);

  assert_pwm_wrap_low_R5: assert property (@(posedge clk) disable iff (rst)
    (mode[0] && irq_lo) |-> !out_lo);
endmodule

bind dual_tmr dual_tmr_chk u_chk (
  .clk(clk), .rst(rst), .restart(restart), .mode(mode_q),
  .out_lo(out_lo), .out_hi(out_hi), .irq_lo(irq_lo), .irq_hi(irq_hi)
);

// File: tb/dual_tmr_tb.sv
`timescale 1ns/1ps
module dual_tmr_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic out_lo, out_hi, irq_lo, irq_hi;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit cmp_en = 1'b0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  dual_tmr u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .out_lo(out_lo), .out_hi(out_hi), .irq_lo(irq_lo), .irq_hi(irq_hi)
  );

  // Behavioural reference model, advanced on each rising edge.
  int m_mode, pc, pa, ps, cl, la, ls, ch, ha, hs;
  bit ol, oh, il, ih;

  always @(posedge clk) begin
    bit tick, lpwm, hpwm, casc, lend, hstep, hend, nol, noh;
    if (rst) begin
      m_mode = 0; pc = 0; pa = 0; ps = 0; cl = 0; la = 0; ls = 0;
      ch = 0; ha = 0; hs = 0; ol = 0; oh = 0; il = 0; ih = 0;
    end else if (wr_en && wr_addr == 2'd0) begin
      m_mode = wr_data[1:0];
      pc = 0; cl = 0; ch = 0; pa = ps; la = ls; ha = hs;
      ol = 0; oh = 0; il = 0; ih = 0;
    end else begin
      tick  = (pc == pa);
      lpwm  = (m_mode == 1 || m_mode == 3);
      hpwm  = (m_mode == 1);
      casc  = (m_mode >= 2);
      lend  = tick && (lpwm ? (cl == 255) : (cl == la));
      hstep = casc ? lend : tick;
      hend  = hstep && (hpwm ? (ch == 255) : (ch == ha));
      nol   = lpwm ? (cl < la) : (ol ^ lend);
      noh   = hpwm ? (ch < ha) : (oh ^ hend);
      if (tick) begin pc = 0; pa = ps; end else pc = pc + 1;
      if (tick) cl = lend ? 0 : cl + 1;
      if (lend) la = ls;
      if (hstep) ch = hend ? 0 : ch + 1;
      if (hend) ha = hs;
      ol = nol; oh = noh; il = lend; ih = hend;
      if (wr_en) begin
        case (wr_addr)
          2'd1: ps = wr_data;
          2'd2: ls = wr_data;
          2'd3: hs = wr_data;
          default: ;
        endcase
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en && !done) begin
      check(out_lo == ol, cur_req, "out_lo", out_lo, ol);
      check(out_hi == oh, cur_req, "out_hi", out_hi, oh);
      check(irq_lo == il, "R10", "irq_lo", irq_lo, il);
      check(irq_hi == ih, "R10", "irq_hi", irq_hi, ih);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    int t0, t1, highs;
    bit prev;
    // R1: reset state
    repeat (3) @(negedge clk);
    cmp_en = 1'b1;
    check(!out_lo && !out_hi && !irq_lo && !irq_hi, "R1", "outputs in reset",
          {out_lo, out_hi, irq_lo, irq_hi}, 0);
    rst = 1'b0;
    run(20);

    // R2, R3, R4: mode 0, P=2, L=3, H=1
    cur_req = "R3";
    wr(2'd1, 8'd2); wr(2'd2, 8'd3); wr(2'd3, 8'd1); wr(2'd0, 8'd0);
    check(!out_lo && !out_hi, "R9", "outputs after restart", {out_lo, out_hi}, 0);
    prev = out_lo; t0 = -1; t1 = -1;
    for (int i = 0; i < 60 && t1 < 0; i++) begin
      @(negedge clk);
      if (out_lo != prev) begin
        if (t0 < 0) t0 = i; else t1 = i;
      end
      prev = out_lo;
    end
    check(t1 - t0 == 12, "R2", "low toggle spacing", t1 - t0, 12);
    cur_req = "R4";
    run(150);

    // R8: change low period mid-run
    cur_req = "R8";
    wr(2'd2, 8'd5);
    wr(2'd1, 8'd0);
    run(300);

    // R5: mode 1, compares 100 and 0
    cur_req = "R5";
    wr(2'd1, 8'd0); wr(2'd2, 8'd100); wr(2'd3, 8'd0); wr(2'd0, 8'd1);
    run(300);
    highs = 0;
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      if (out_lo) highs++;
      if (out_hi) highs += 1000;
    end
    check(highs == 100, "R5", "high cycles per PWM period", highs, 100);
    wr(2'd2, 8'd255); wr(2'd3, 8'd1);
    run(600);

    // R6: mode 2 chained toggle
    cur_req = "R6";
    wr(2'd1, 8'd1); wr(2'd2, 8'd2); wr(2'd3, 8'd3); wr(2'd0, 8'd2);
    run(300);
    wr(2'd3, 8'd0);
    run(100);

    // R7: mode 3 chained with PWM low
    cur_req = "R7";
    wr(2'd1, 8'd0); wr(2'd2, 8'd64); wr(2'd3, 8'd1); wr(2'd0, 8'd3);
    run(1200);

    // R9: restart mid-run
    cur_req = "R9";
    run(37);
    wr(2'd0, 8'd3);
    check(!out_lo && !out_hi && !irq_lo && !irq_hi, "R9", "restart clears",
          {out_lo, out_hi, irq_lo, irq_hi}, 0);
    run(100);

    // R1: reset mid-run
    cur_req = "R1";
    rst = 1'b1;
    run(2);
    check(!out_lo && !out_hi && !irq_lo && !irq_hi, "R1", "reset clears",
          {out_lo, out_hi, irq_lo, irq_hi}, 0);
    rst = 1'b0;
    run(20);
    finish_up();
  end
endmodule